// File: doc/BRIEF.md
# Edge-Triggered Pin Event Collector

This block watches a vector of general-purpose input pins, brings each one into the local clock domain through a short flip-flop chain and compares each sample with the one before it to find transitions. For each pin, two independent enable bits choose which transitions count: a low-to-high change, a high-to-low change, or both. A qualifying transition sets a sticky per-pin cause bit. The cause bit stays set until software clears it.

An event mask chooses which cause bits may reach the single level-sensitive interrupt output. The interrupt output may be OR-ed with other sources at the system level. Software uses a 32-bit register port with single-cycle write strobes and a read strobe. It programs the enables and the mask, reads a pending view that already has the mask applied, and acknowledges events by writing ones to a clear register.

Top module: `gpio_evt_top`

## Requirements
- R1: After synchronous reset, the rise enables, fall enables, mask and cause bits all read as 0, and `irq_o` is low.
- R2: The rise-enable register is at offset 0x44 and the fall-enable register is at 0x48. Bit n of each controls pin n, and both registers read back what was written.
- R3: A low-to-high change on pin n whose rise enable is set sets cause bit n. The cause bit is visible three clock edges after the pin changes: two synchronizer stages, then the cause register.
- R4: A high-to-low change on pin n whose fall enable is set sets cause bit n. With both enables set, either direction of change sets the bit.
- R5: A transition whose matching enable is clear leaves the cause bit unchanged.
- R6: A cause bit stays set after its enables are cleared and after the pin changes again.
- R7: A read of offset 0x80 returns the cause bits ANDed with the mask. Read data appears on `rdata_o` on the edge after the cycle in which `rd_en_i` is high. Reads of any other offset, including 0x98, return 0, except the enable and mask registers.
- R8: The mask register is at offset 0x94 and reads back what was written.
- R9: Writing to offset 0x98 clears every cause bit whose data bit is 1. Cause bits whose data bit is 0 are left unchanged.
- R10: When a qualifying transition and a clear for the same bit fall in the same cycle, the cause bit ends up set.
- R11: `irq_o` is high exactly one cycle after any bit of (cause AND mask) is 1, and low one cycle after that product becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pin_i | input | NPINS | Asynchronous pin levels |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Combined level interrupt |

## Verification
The checker assumes that a clear write and a new transition on the same bit can coincide, and that enables can change at any time. It also assumes that reset lasts at least one edge. It does not assume that the pins are quiet. The stimulus changes pins only at falling clock edges and holds them for at least four cycles, so the bench's per-transition model stays exact. Pins are kept low through reset, so no edge comes from the reset value. The stimulus forces the same-cycle clear and transition case by issuing the write exactly two edges after the pin changes.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
  parameter int ADDR_W = 8;
  parameter int DATA_W = 32;
  parameter logic [ADDR_W-1:0] OFS_RISE_EN = 8'h44;
  parameter logic [ADDR_W-1:0] OFS_FALL_EN = 8'h48;
  parameter logic [ADDR_W-1:0] OFS_PENDING = 8'h80;
  parameter logic [ADDR_W-1:0] OFS_MASK    = 8'h94;
  parameter logic [ADDR_W-1:0] OFS_CLEAR   = 8'h98;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int NPINS  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [NPINS-1:0] pin_i,
  output logic [NPINS-1:0] rise_o,
  output logic [NPINS-1:0] fall_o
);
  logic [NPINS-1:0] chain_q [STAGES];
  logic [NPINS-1:0] prev_q;
  logic             armed_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
      prev_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      chain_q[0] <= pin_i;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
      prev_q  <= chain_q[STAGES-1];
      armed_q <= 1'b1;
    end
  end

  // compare newest settled sample with the one before it
  always_comb begin
    rise_o = armed_q ? ( chain_q[STAGES-1] & ~prev_q) : '0;
    fall_o = armed_q ? (~chain_q[STAGES-1] &  prev_q) : '0;
  end
endmodule

// File: rtl/gpio_evt_regs.sv
module gpio_evt_regs
  import gpio_evt_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NPINS-1:0]  cause_i,
  output logic [NPINS-1:0]  rise_en_o,
  output logic [NPINS-1:0]  fall_en_o,
  output logic [NPINS-1:0]  mask_o,
  output logic              clr_wr_o,
  output logic [NPINS-1:0]  clr_bits_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] rd_mux;

  function automatic logic [DATA_W-1:0] widen(input logic [NPINS-1:0] v);
    logic [DATA_W-1:0] r;
    r = '0;
    r[NPINS-1:0] = v;
    return r;
  endfunction

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rise_en_o <= '0;
      fall_en_o <= '0;
      mask_o    <= '0;
    end else if (wr_en_i) begin
      if (addr_i == OFS_RISE_EN) rise_en_o <= wdata_i[NPINS-1:0];
      if (addr_i == OFS_FALL_EN) fall_en_o <= wdata_i[NPINS-1:0];
      if (addr_i == OFS_MASK)    mask_o    <= wdata_i[NPINS-1:0];
    end
  end

  assign clr_wr_o   = wr_en_i && (addr_i == OFS_CLEAR);
  assign clr_bits_o = clr_wr_o ? wdata_i[NPINS-1:0] : '0;

  always_comb begin
    unique case (addr_i)
      OFS_RISE_EN: rd_mux = widen(rise_en_o);
      OFS_FALL_EN: rd_mux = widen(fall_en_o);
      OFS_MASK:    rd_mux = widen(mask_o);
      OFS_PENDING: rd_mux = widen(cause_i & mask_o);
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)        rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end
endmodule

// File: rtl/gpio_cause_bank.sv
module gpio_cause_bank #(
  parameter int NPINS = 32
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [NPINS-1:0] hit_i,
  input  logic [NPINS-1:0] clr_i,
  output logic [NPINS-1:0] cause_o
);
  // a new hit outranks a clear of the same bit
  always_ff @(posedge clk_i) begin
    if (rst_i) cause_o <= '0;
    else       cause_o <= (cause_o & ~clr_i) | hit_i;
  end
endmodule

// File: rtl/gpio_evt_top.sv
module gpio_evt_top
  import gpio_evt_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [NPINS-1:0]  pin_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [NPINS-1:0] rise_p, fall_p, rise_en, fall_en, mask_q;
  logic [NPINS-1:0] clr_bits, cause_q, hits;
  logic             clr_wr;

  gpio_pin_sync #(.NPINS(NPINS), .STAGES(STAGES)) sync_i (
    .clk_i(clk_i), .rst_i(rst_i), .pin_i(pin_i),
    .rise_o(rise_p), .fall_o(fall_p)
  );

  gpio_evt_regs #(.NPINS(NPINS)) regs_i (
    .clk_i(clk_i), .rst_i(rst_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .cause_i(cause_q),
    .rise_en_o(rise_en), .fall_en_o(fall_en), .mask_o(mask_q),
    .clr_wr_o(clr_wr), .clr_bits_o(clr_bits), .rdata_o(rdata_o)
  );

  assign hits = (rise_p & rise_en) | (fall_p & fall_en);

  gpio_cause_bank #(.NPINS(NPINS)) bank_i (
    .clk_i(clk_i), .rst_i(rst_i), .hit_i(hits), .clr_i(clr_bits),
    .cause_o(cause_q)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) irq_o <= 1'b0;
    else       irq_o <= |(cause_q & mask_q);
  end
endmodule

// File: rtl/gpio_evt_chk.sv
module gpio_evt_chk #(
  parameter int NPINS = 32
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             irq_o,
  input logic [NPINS-1:0] cause,
  input logic [NPINS-1:0] mask,
  input logic [NPINS-1:0] hits,
  input logic             clr_wr
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk_i)
    rst_i |=> (!irq_o && cause == '0));

  // R11
  irq_tracks_pending_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> (irq_o == $past(|(cause & mask))));

  // R6
  sticky_without_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !clr_wr |=> ((cause & $past(cause)) == $past(cause)));

  // R5
  set_needs_hit_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> ((cause & ~$past(cause) & ~$past(hits)) == '0));

  // R10
  hit_beats_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    clr_wr |=> ((cause & $past(hits)) == $past(hits)));
endmodule

bind gpio_evt_top gpio_evt_chk #(.NPINS(NPINS)) chk_i (
  .clk_i(clk_i), .rst_i(rst_i), .irq_o(irq_o), .cause(cause_q),
  .mask(mask_q), .hits(hits), .clr_wr(clr_wr)
);

// File: tb/gpio_evt_top_tb_top.sv
module gpio_evt_top_tb_top;
  localparam int NP = 32;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [NP-1:0] pins = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0, fails = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_pend = 1'b0;
  logic [NP-1:0] m_rise = '0, m_fall = '0, m_mask = '0, m_cause = '0;

  always #2 clk = ~clk;

  gpio_evt_top dut_i (
    .clk_i(clk), .rst_i(rst), .pin_i(pins), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // monitor: compare read data one edge after the strobe
  always @(posedge clk) rd_pend <= rd_en;
  always @(negedge clk) begin
    if (rd_pend && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        fails++;
        $display("FAIL %s: rdata got %h expected %h", t, rdata, e);
      end
    end
  end

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(t);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq !== e) begin
      fails++;
      $display("FAIL %s: irq got %b expected %b", t, irq, e);
    end
  endtask

  task automatic drive_pins(input logic [NP-1:0] v);
    logic [NP-1:0] hit;
    hit = (v & ~pins & m_rise) | (~v & pins & m_fall);
    @(negedge clk);
    pins = v;
    repeat (4) @(negedge clk);
    m_cause = m_cause | hit;
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk_irq(1'b0, "R1");
    bus_rd(8'h44, 32'h0, "R1 rise");
    bus_rd(8'h48, 32'h0, "R1 fall");
    bus_rd(8'h94, 32'h0, "R1 mask");
    bus_rd(8'h80, 32'h0, "R1 pending");

    // R2 / R8 programming
    m_rise = 32'h0000_00FF; m_fall = 32'h0000_0FF0; m_mask = 32'hFFFF_FFFF;
    bus_wr(8'h44, m_rise);
    bus_wr(8'h48, m_fall);
    bus_wr(8'h94, m_mask);
    bus_rd(8'h44, m_rise, "R2 rise readback");
    bus_rd(8'h48, m_fall, "R2 fall readback");
    bus_rd(8'h94, m_mask, "R8 mask readback");
    bus_rd(8'h98, 32'h0, "R7 clear offset reads zero");

    // R3 / R5 rising edges on 0..15, only 0..7 enabled
    drive_pins(32'h0000_FFFF);
    bus_rd(8'h80, m_cause & m_mask, "R3 R5 rising causes");
    chk_irq(1'b1, "R11 asserted");

    // R9 partial clear
    bus_wr(8'h98, 32'h0000_000F);
    m_cause = m_cause & ~32'h0000_000F;
    bus_rd(8'h80, m_cause, "R9 partial clear");

    // R4 falling edges, bits 4..7 have both enables
    drive_pins(32'h0000_0000);
    bus_rd(8'h80, m_cause & m_mask, "R4 falling causes");

    // R7 / R11 masking
    m_mask = 32'h0000_0F00;
    bus_wr(8'h94, m_mask);
    bus_rd(8'h80, m_cause & m_mask, "R7 masked pending");
    chk_irq(1'b1, "R11 masked still pending");
    m_mask = 32'h0;
    bus_wr(8'h94, m_mask);
    wait_cycles(1);
    chk_irq(1'b0, "R11 deasserted by mask");
    bus_rd(8'h80, 32'h0, "R7 fully masked");

    // R6 sticky with enables removed
    m_rise = '0; m_fall = '0; m_mask = 32'hFFFF_FFFF;
    bus_wr(8'h44, 32'h0);
    bus_wr(8'h48, 32'h0);
    bus_wr(8'h94, m_mask);
    drive_pins(32'h0000_00FF);
    bus_rd(8'h80, m_cause, "R6 R5 sticky, no new causes");

    // R10 transition and clear in one cycle on bit 20
    m_rise = 32'h0010_0000; m_fall = 32'h0010_0000;
    bus_wr(8'h44, m_rise);
    bus_wr(8'h48, m_fall);
    drive_pins(32'h0010_00FF);
    bus_rd(8'h80, m_cause, "R3 bit 20 set");
    @(negedge clk);
    pins = 32'h0000_00FF;
    @(negedge clk);
    @(negedge clk);
    wr_en = 1'b1; addr = 8'h98; wdata = 32'h0010_0000;
    @(negedge clk);
    wr_en = 1'b0;
    wait_cycles(2);
    bus_rd(8'h80, m_cause, "R10 hit beats clear");

    // R9 / R11 full clear
    bus_wr(8'h98, 32'hFFFF_FFFF);
    m_cause = '0;
    wait_cycles(1);
    chk_irq(1'b0, "R11 low after clear");
    bus_rd(8'h80, 32'h0, "R9 all cleared");

    wait_cycles(2);
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R7: reads outstanding got %0d expected 0", exp_q.size());
    end
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule